// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial bus (I2C-style). It gives a bus host byte access to a 256-byte addressed store. SCL and SDA are sampled onto a fast system clock through two-stage synchronizers. Start and stop conditions are found there, and the block then works through device addressing, memory addressing, data transfer and acknowledge on an open-drain data output. The output is an active-high pull-down request, `sda_pull_o`. An external open-drain pad turns it into a low on the wire.

The store and its commit timer sit outside the block. They are reached through a single internal port: a pointer-based address, a write strobe with data, and a read strobe whose data must be valid in the same system cycle. A commit pulse marks the stop that ends a write transaction. The store then raises `busy_i` for the length of its internal write. While `busy_i` is high the slave refuses its own address, so a host can poll for the end of the commit.

The slave keeps an internal byte pointer that persists between transactions. This pointer makes current-address reads and sequential reads possible, and it wraps from the top of the store back to zero.

Top module: `twowire_mem_slave`

## Requirements
- R1: After reset the slave does not pull SDA, raises no memory strobe and no commit pulse, and its pointer is 00h.
- R2: The device byte is received MSB first as 1010, then the strap bits in the order strap_i[2], strap_i[1], strap_i[0], then the direction bit (1 = read). On any other device byte the slave pulls SDA at no point until the next start condition.
- R3: In a write transaction the slave acknowledges the device byte, the memory address byte and every data byte by pulling SDA low for the whole ninth SCL clock.
- R4: In a write transaction the first byte after the device byte loads the pointer. Each later byte is written to the store at the pointer, with one mem_we_o cycle, and the pointer then steps by one, wrapping from FFh to 00h. mem_we_o and mem_re_o are never high together.
- R5: A stop after a transaction that wrote at least one data byte gives exactly one commit_o pulse. A stop after a transaction that wrote no data byte gives none.
- R6: A read with no preceding address byte returns the byte at the pointer. The pointer keeps its value between transactions.
- R7: A repeated start after an address-only write transaction starts a new device byte without a stop, so the read that follows begins at the just-loaded address.
- R8: In a read the slave sends a further byte at the next pointer after each master acknowledge, wrapping from FFh to 00h. After a master non-acknowledge it releases SDA and sends nothing more.
- R9: While busy_i is high the slave does not acknowledge a matching device byte. Once busy_i is low it acknowledges again.
- R10: The slave changes its SDA drive only while SCL is low, except when it releases the line on a start or stop condition.
- R11: A stop condition returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull_o | output | 1 | High to pull the open-drain SDA line low |
| strap_i | input | 3 | Hard-wired device address bits |
| busy_i | input | 1 | High while the store commits a write |
| mem_addr_o | output | 8 | Store address (the internal pointer) |
| mem_wdata_o | output | 8 | Byte to write into the store |
| mem_we_o | output | 1 | One-cycle store write strobe |
| mem_re_o | output | 1 | One-cycle store read strobe; data sampled that cycle |
| mem_rdata_i | input | 8 | Store read data for mem_addr_o |
| commit_o | output | 1 | One-cycle pulse on a stop that ends a write |

## Verification
The host model runs several kinds of transfer. Single-byte writes and multi-byte writes that cross FFh separate correct pointer stepping and wrap from loss of the high bit. Current-address reads right after reset and after a write tell a persistent pointer from one that is reset or reloaded. Random reads through a repeated start show that the address byte is honoured without a stop. A long sequential read across the top of the store, ended by a non-acknowledge, checks both the read-side wrap and the release of SDA. A wrong strap pattern and a busy interval both have to give silent address bytes, and the commit count tells transactions with data apart from those that only carry an address.

// File: rtl/twm_pkg.sv
package twm_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_MACK
  } twm_state_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_MADDR,
    K_DATA
  } twm_kind_e;

endpackage

// File: rtl/twm_line_sync.sv
module twm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_d;
  logic              sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/twm_ptr.sv
module twm_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);

  logic [AW-1:0] ptr_nx;
  logic          ptr_en;

  always_comb begin
    ptr_en = ld | inc;
    if (ld) ptr_nx = ld_val;
    else    ptr_nx = ptr + {{(AW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (ptr_en) ptr <= ptr_nx;
  end

endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
  parameter int         AW          = 8,
  parameter int         STRAP_W     = 3,
  parameter logic [3:0] DEV_PREFIX  = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  output logic [AW-1:0]      mem_addr_o,
  output logic [7:0]         mem_wdata_o,
  output logic               mem_we_o,
  output logic               mem_re_o,
  input  logic [7:0]         mem_rdata_i,
  output logic               commit_o
);
  import twm_pkg::*;

  localparam int BW  = 8;
  localparam int BCW = $clog2(BW);
  localparam logic [BCW-1:0] BIT_LAST = BCW'(BW - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_ff;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sn = rst_ff[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  twm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sn),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twm_state_e     st_q, st_n;
  twm_kind_e      kind_q, kind_n;
  logic [BCW-1:0] bit_q, bit_n;
  logic           full_q, full_n;
  logic [BW-1:0]  rx_q, rx_n;
  logic [BW-1:0]  tx_q, tx_n;
  logic           rw_q, rw_n;
  logic           mack_q, mack_n;
  logic           pull_q, pull_n;
  logic           wrote_q, wrote_n;
  logic           ptr_ld, ptr_inc;
  logic           we, re, commit;
  logic [AW-1:0]  ptr;
  logic           dev_match;

  twm_ptr #(.AW(AW)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_sn),
    .ld     (ptr_ld),
    .ld_val (rx_q[AW-1:0]),
    .inc    (ptr_inc),
    .ptr    (ptr)
  );

  assign dev_match = (rx_q[BW-1:1] == {DEV_PREFIX, strap_i}) && !busy_i;

  always_comb begin
    st_n    = st_q;
    kind_n  = kind_q;
    bit_n   = bit_q;
    full_n  = full_q;
    rx_n    = rx_q;
    tx_n    = tx_q;
    rw_n    = rw_q;
    mack_n  = mack_q;
    pull_n  = pull_q;
    wrote_n = wrote_q;
    ptr_ld  = 1'b0;
    ptr_inc = 1'b0;
    we      = 1'b0;
    re      = 1'b0;
    commit  = 1'b0;
    if (start_det) begin
      st_n   = S_RX;
      kind_n = K_DEV;
      bit_n  = '0;
      full_n = 1'b0;
      pull_n = 1'b0;
    end else if (stop_det) begin
      st_n    = S_IDLE;
      pull_n  = 1'b0;
      full_n  = 1'b0;
      commit  = wrote_q;
      wrote_n = 1'b0;
    end else begin
      unique case (st_q)
        S_RX: begin
          if (scl_rise) begin
            rx_n  = {rx_q[BW-2:0], sda_s};
            bit_n = bit_q + 1'b1;
            if (bit_q == BIT_LAST) full_n = 1'b1;
          end else if (scl_fall && full_q) begin
            full_n = 1'b0;
            unique case (kind_q)
              K_DEV: begin
                if (dev_match) begin
                  pull_n = 1'b1;
                  rw_n   = rx_q[0];
                  st_n   = S_ACK;
                end else begin
                  st_n = S_IDLE;
                end
              end
              K_MADDR: begin
                pull_n = 1'b1;
                ptr_ld = 1'b1;
                st_n   = S_ACK;
              end
              default: begin
                pull_n  = 1'b1;
                we      = 1'b1;
                ptr_inc = 1'b1;
                wrote_n = 1'b1;
                st_n    = S_ACK;
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bit_n = '0;
            if (kind_q == K_DEV && rw_q) begin
              re      = 1'b1;
              ptr_inc = 1'b1;
              tx_n    = mem_rdata_i;
              pull_n  = ~mem_rdata_i[BW-1];
              st_n    = S_TX;
            end else begin
              pull_n = 1'b0;
              st_n   = S_RX;
              kind_n = (kind_q == K_DEV) ? K_MADDR : K_DATA;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bit_q == BIT_LAST) begin
              pull_n = 1'b0;
              st_n   = S_MACK;
            end else begin
              bit_n  = bit_q + 1'b1;
              tx_n   = {tx_q[BW-2:0], 1'b0};
              pull_n = ~tx_q[BW-2];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              re      = 1'b1;
              ptr_inc = 1'b1;
              tx_n    = mem_rdata_i;
              pull_n  = ~mem_rdata_i[BW-1];
              bit_n   = '0;
              st_n    = S_TX;
            end else begin
              st_n = S_IDLE;
            end
          end
        end
        default: begin
          pull_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q    <= S_IDLE;
      kind_q  <= K_DEV;
      bit_q   <= '0;
      full_q  <= 1'b0;
      rx_q    <= '0;
      tx_q    <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      pull_q  <= 1'b0;
      wrote_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      kind_q  <= kind_n;
      bit_q   <= bit_n;
      full_q  <= full_n;
      rx_q    <= rx_n;
      tx_q    <= tx_n;
      rw_q    <= rw_n;
      mack_q  <= mack_n;
      pull_q  <= pull_n;
      wrote_q <= wrote_n;
    end
  end

  assign sda_pull_o  = pull_q;
  assign mem_addr_o  = ptr;
  assign mem_wdata_o = rx_q;
  assign mem_we_o    = we;
  assign mem_re_o    = re;
  assign commit_o    = commit;

endmodule

// File: rtl/twm_checker.sv
module twm_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          start_det,
  input logic          stop_det,
  input logic          sda_pull,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr,
  input logic          commit
);

  logic [AW-1:0] addr_nx;
  assign addr_nx = mem_addr + {{(AW-1){1'b0}}, 1'b1};

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |=> (mem_addr == $past(addr_nx))); // R4

  AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> stop_det); // R5

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det))); // R10

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull); // R11

endmodule

bind twowire_mem_slave twm_checker #(.AW(AW)) u_twm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_pull  (sda_pull_o),
  .mem_we    (mem_we_o),
  .mem_re    (mem_re_o),
  .mem_addr  (mem_addr_o),
  .commit    (commit_o)
);

// File: tb/test_twowire_mem_slave.sv
`timescale 1ns/1ps
module test_twowire_mem_slave;

  localparam logic [2:0] STRAP = 3'b101;
  localparam int Q = 50;

  typedef struct {
    logic [7:0] val;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       busy = 1'b0;
  logic       sda_pull;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we, mem_re, commit;
  wire        sda_bus = sda_m & ~sda_pull;

  logic [7:0] mem     [256];
  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr;
  int         n_chk = 0;
  int         n_fail = 0;
  int         n_commit = 0;
  exp_t       exp_q[$];
  logic [7:0] got_b;
  string      got_req;
  event       got_ev;

  always #2.5 clk = ~clk;

  twowire_mem_slave i_twowire_mem_slave (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_bus),
    .sda_pull_o  (sda_pull),
    .strap_i     (STRAP),
    .busy_i      (busy),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_we_o    (mem_we),
    .mem_re_o    (mem_re),
    .mem_rdata_i (mem_rdata),
    .commit_o    (commit)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (commit) n_commit <= n_commit + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compares every byte the host captures against the scoreboard
  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) begin
        check(got_req, {24'd0, got_b}, 32'hdead);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, {24'd0, got_b}, {24'd0, e.val});
      end
    end
  end

  task automatic cond_start;
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic cond_stop;
    sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input string req, input logic exp_ack);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
    end
    sda_m = 1'b1; #Q; scl = 1'b1; #(Q/2);
    s1 = sda_bus; #Q;
    s2 = sda_bus; #(Q/2);
    scl = 1'b0; #Q;
    check(req, {31'd0, ~s1}, {31'd0, exp_ack});
    if (exp_ack) check("R10", {31'd0, s2}, {31'd0, s1});
  endtask

  task automatic recv_byte(input logic host_ack, input string req);
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; #Q; scl = 1'b1; #Q; b[i] = sda_bus; #Q; scl = 1'b0; #Q;
    end
    sda_m = ~host_ack; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
    got_b = b;
    got_req = req;
    ->got_ev;
    #1;
  endtask

  task automatic write_txn(input logic [7:0] a, input int n, input logic [7:0] d0);
    int c0;
    logic [7:0] pa;
    c0 = n_commit;
    pa = a;
    cond_start();
    send_byte({4'b1010, STRAP, 1'b0}, "R2", 1'b1);
    send_byte(a, "R3", 1'b1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = d0 + 8'(k * 17);
      send_byte(d, "R3", 1'b1);
      ref_mem[pa] = d;
      pa = pa + 8'd1;
    end
    cond_stop();
    ref_ptr = pa;
    check("R5", n_commit - c0, (n > 0) ? 1 : 0);
  endtask

  task automatic read_txn(input int n, input string req);
    cond_start();
    send_byte({4'b1010, STRAP, 1'b1}, req, 1'b1);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.val = ref_mem[ref_ptr];
      e.req = req;
      exp_q.push_back(e);
      ref_ptr = ref_ptr + 8'd1;
      recv_byte(k != n - 1, req);
    end
    #Q;
    check("R8", {31'd0, sda_bus}, 32'd1);
    cond_stop();
    check("R11", {31'd0, sda_bus}, 32'd1);
  endtask

  task automatic random_read(input logic [7:0] a, input int n, input string req);
    int c0;
    c0 = n_commit;
    cond_start();
    send_byte({4'b1010, STRAP, 1'b0}, req, 1'b1);
    send_byte(a, req, 1'b1);
    ref_ptr = a;
    read_txn(n, req);
    check("R5", n_commit - c0, 0);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    ref_ptr = 8'h00;
    #102;
    rst_n = 1'b1;
    #100;
    check("R1", {31'd0, sda_bus}, 32'd1);
    check("R1", {31'd0, mem_we | mem_re}, 32'd0);
    check("R1", n_commit, 0);

    // current-address read right after reset: pointer starts at 00h
    read_txn(1, "R1");

    // wrong strap pattern: address and following byte are ignored
    cond_start();
    send_byte({4'b1010, ~STRAP, 1'b0}, "R2", 1'b0);
    send_byte(8'h33, "R2", 1'b0);
    send_byte(8'h99, "R2", 1'b0);
    cond_stop();
    check("R2", n_commit, 0);

    write_txn(8'h10, 1, 8'hA5);
    write_txn(8'hFE, 3, 8'h40);   // R4 wrap FEh, FFh, 00h

    // busy: polling sees no acknowledge until busy drops
    busy = 1'b1;
    cond_start();
    send_byte({4'b1010, STRAP, 1'b0}, "R9", 1'b0);
    cond_stop();
    busy = 1'b0;
    cond_start();
    send_byte({4'b1010, STRAP, 1'b0}, "R9", 1'b1);
    cond_stop();

    read_txn(2, "R6");            // continues at 01h
    read_txn(1, "R6");
    random_read(8'h10, 1, "R7");
    random_read(8'h33, 1, "R2");  // untouched by the ignored transfer
    random_read(8'hFC, 6, "R8");  // wraps through 00h

    #200;
    check("R8", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule